// File: doc/BRIEF.md
# Packet Slot Command Engine

This block interprets command words written by a host to the buffer-management command port of a network controller. It keeps two circular slot queues, one for received frames and one for frames queued for transmission. Each queue is a pair of 4-bit write and read pointers, and the block holds no frame bytes.

Commands can:
- allocate a transmit buffer number;
- flush both queues;
- drop the oldest received frame, on its own or together with a receive-interrupt re-evaluation;
- drop the oldest transmit entry;
- hand a frame to the transmitter.

Around the commands, the block also:
- records frame arrivals from the receive path;
- reacts to receive-control writes that flush the queues;
- maintains the interrupt status byte and the receive-queue-empty flag;
- drives a masked interrupt line.

When a transmit is requested while the link is down, the block sets the transmit error flags selected by the transmit-control word. It also asks the owner of that word to drop the transmit-enable bit.

Every output is registered. A command written at clock edge k is visible on the outputs right after edge k. The one-cycle pulses `tx_start` and `txen_clear` are high from edge k to edge k+1.

Top module: `mmu_cmd_engine`

## Requirements
- R1: After synchronous reset, all four pointers, `alloc_pnr`, `int_status`, the pulses, `irq` and both error flags are 0, and `rx_empty` is 1.
- R2: The command code is `cmd_data[7:4]`, taken only when `cmd_we` is 1. The codes 0 (no-op) and 10 (release), and every code outside {2,4,6,7,8,12,14}, leave all outputs unchanged.
- R3: Code 2 (allocate) loads `alloc_pnr` with {0, a 7-bit running counter}. The counter starts at 0 and then increments, wrapping 127 to 0. Code 2 also sets `int_status` bit 3.
- R4: A `rx_push` pulse advances `rx_in_ptr`, sets `int_status` bit 0 and clears `rx_empty`. The push is dropped when 15 slots are occupied (`rx_in_ptr`+1 equals `rx_out_ptr`). It is also ignored in any cycle with `cmd_we` or `rxc_we` high.
- R5: Code 8 (remove and release) clears `int_status` bit 0 and advances `rx_out_ptr` if the RX queue is not empty. If frames then remain, bit 0 is set again and `rx_empty` is 0; otherwise `rx_empty` is 1.
- R6: Code 6 advances `rx_out_ptr` when the RX queue is not empty, updates `rx_empty` and leaves bit 0 alone. Code 7 advances `tx_out_ptr` when the TX queue is not empty.
- R7: Codes 4 and 14 zero all four pointers, set `rx_empty` and clear `int_status` bit 0.
- R8: Code 12 with `link_up`=1 and `tx_ctl[0]`=1 pulses `tx_start`, advances both TX pointers and sets `int_status` bits 1 and 2. With `tx_ctl[0]`=0 it does nothing.
- R9: Code 12 with `link_up`=0 sets `eph_lost_carrier` if `tx_ctl[10]` and `eph_sqe` if `tx_ctl[12]`. It pulses `txen_clear` when either of those bits is set. It clears bit 1, sets bit 5 and flushes both queues as in R7.
- R10: All pointers wrap modulo 16.
- R11: A `rxc_we` write with bit 15 set flushes both queues. A write with bit 8 clear flushes only the RX queue, leaving the TX pointers unchanged.
- R12: `irq` is 1 exactly when some bit is set in both `int_status` and `int_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_data | input | 16 | Command word, code in bits 7:4 |
| tx_ctl | input | 16 | Transmit-control word (bit 0 enable, 10 and 12 error policies) |
| link_up | input | 1 | Link is connected |
| rxc_we | input | 1 | Receive-control write strobe |
| rxc_data | input | 16 | Receive-control word (bit 15 soft reset, bit 8 accept-all) |
| rx_push | input | 1 | One frame has arrived from the receive path |
| int_mask | input | 8 | Interrupt enable per status bit |
| rx_in_ptr | output | 4 | RX write pointer |
| rx_out_ptr | output | 4 | RX read pointer |
| tx_in_ptr | output | 4 | TX write pointer |
| tx_out_ptr | output | 4 | TX read pointer |
| alloc_pnr | output | 8 | Allocated packet number |
| int_status | output | 8 | Interrupt status bits |
| irq | output | 1 | Masked interrupt request |
| rx_empty | output | 1 | RX queue empty flag |
| tx_start | output | 1 | One-cycle request to transmit a frame |
| txen_clear | output | 1 | One-cycle request to drop the transmit-enable bit |
| eph_lost_carrier | output | 1 | Sticky lost-carrier error |
| eph_sqe | output | 1 | Sticky signal-quality error |

## Verification
Directed sequences exercise specific cases:
- filling the RX queue to 15 frames shows whether the full test drops the sixteenth push;
- long push/release runs cross the modulo-16 wrap;
- releases with one frame versus several queued tell apart the two outcomes of the re-armed receive interrupt;
- enqueues under link down with each error-policy bit on its own separate the lost-carrier and signal-quality paths.

A seeded random mix then interleaves all sixteen command codes, frame arrivals, receive-control writes, link changes and transmit-control values. It compares every output after every operation with a model in the bench, which catches wrong priority between flushes, pushes and removals.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int INT_W      = 8;
    localparam int IB_RCV     = 0;
    localparam int IB_TX      = 1;
    localparam int IB_TXEMPTY = 2;
    localparam int IB_ALLOC   = 3;
    localparam int IB_EPH     = 5;

    localparam int TXC_EN     = 0;
    localparam int TXC_LCAR   = 10;
    localparam int TXC_SQE    = 12;
    localparam int RXC_SOFT   = 15;
    localparam int RXC_ALL    = 8;

    typedef enum logic [3:0] {
        CMD_NOP       = 4'd0,
        CMD_ALLOC     = 4'd2,
        CMD_RESET_MMU = 4'd4,
        CMD_RM_RX     = 4'd6,
        CMD_RM_TX     = 4'd7,
        CMD_RM_REL_RX = 4'd8,
        CMD_RELEASE   = 4'd10,
        CMD_ENQUEUE   = 4'd12,
        CMD_RESET_FIF = 4'd14
    } mmu_cmd_e;

    typedef struct packed {
        logic alloc;
        logic flush_all;
        logic rm_rx;
        logic rm_tx;
        logic rm_rel_rx;
        logic enqueue;
    } mmu_op_t;

    function automatic logic [3:0] cmd_field(input logic [15:0] word);
        return word[7:4];
    endfunction

endpackage

// File: rtl/mmu_cmd_decode.sv
module mmu_cmd_decode
    import mmu_pkg::*;
(
    input  logic        cmd_we,
    input  logic [15:0] cmd_data,
    output mmu_op_t     op
);

    logic [3:0] code;

    always_comb begin
        code = cmd_field(cmd_data);
        op   = '0;
        if (cmd_we) begin
            unique case (code)
                CMD_ALLOC:     op.alloc     = 1'b1;
                CMD_RESET_MMU,
                CMD_RESET_FIF: op.flush_all = 1'b1;
                CMD_RM_RX:     op.rm_rx     = 1'b1;
                CMD_RM_TX:     op.rm_tx     = 1'b1;
                CMD_RM_REL_RX: op.rm_rel_rx = 1'b1;
                CMD_ENQUEUE:   op.enqueue   = 1'b1;
                default:       op           = '0;
            endcase
        end
    end

    // R2: at most one action is decoded from one command word
    always_comb begin
        a_r2_single_op: assert ($onehot0(op));
    end

endmodule

// File: rtl/mmu_slot_queue.sv
module mmu_slot_queue #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] in_ptr,
    output logic [PTR_W-1:0] out_ptr,
    output logic             empty,
    output logic             full,
    output logic             single
);

    logic [PTR_W-1:0] in_q, out_q, in_inc, out_inc;
    logic             push_ok, pop_ok;

    assign in_inc  = PTR_W'(in_q + 1'b1);
    assign out_inc = PTR_W'(out_q + 1'b1);
    assign empty   = (in_q == out_q);
    assign full    = (in_inc == out_q);
    assign single  = (out_inc == in_q);
    assign push_ok = push & ~full;
    assign pop_ok  = pop & (~empty | push_ok);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            in_q  <= '0;
            out_q <= '0;
        end else begin
            if (push_ok) in_q  <= in_inc;
            if (pop_ok)  out_q <= out_inc;
        end
    end

    assign in_ptr  = in_q;
    assign out_ptr = out_q;

    // R10: a pointer only steps by one (with wrap) or returns to zero
    a_r10_in_step: assert property (@(posedge clk) disable iff (rst)
        (in_q != $past(in_q)) |-> (in_q == PTR_W'($past(in_q) + 1'b1) || in_q == '0));
    a_r10_out_step: assert property (@(posedge clk) disable iff (rst)
        (out_q != $past(out_q)) |-> (out_q == PTR_W'($past(out_q) + 1'b1) || out_q == '0));

endmodule

// File: rtl/mmu_cmd_engine.sv
module mmu_cmd_engine
    import mmu_pkg::*;
#(
    parameter int SLOT_BITS  = 4,
    parameter int ALLOC_BITS = 7,
    parameter int PNR_W      = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_we,
    input  logic [15:0]          cmd_data,
    input  logic [15:0]          tx_ctl,
    input  logic                 link_up,
    input  logic                 rxc_we,
    input  logic [15:0]          rxc_data,
    input  logic                 rx_push,
    input  logic [INT_W-1:0]     int_mask,
    output logic [SLOT_BITS-1:0] rx_in_ptr,
    output logic [SLOT_BITS-1:0] rx_out_ptr,
    output logic [SLOT_BITS-1:0] tx_in_ptr,
    output logic [SLOT_BITS-1:0] tx_out_ptr,
    output logic [PNR_W-1:0]     alloc_pnr,
    output logic [INT_W-1:0]     int_status,
    output logic                 irq,
    output logic                 rx_empty,
    output logic                 tx_start,
    output logic                 txen_clear,
    output logic                 eph_lost_carrier,
    output logic                 eph_sqe
);

    mmu_op_t op;
    logic    link_fail, send;
    logic    rx_flush, tx_flush, rx_push_en, rx_pop, tx_pop;
    logic    rxq_empty, rxq_full, rxq_single;
    logic    txq_empty, txq_full, txq_single;
    logic    rx_push_ok;

    logic [ALLOC_BITS-1:0] alloc_cnt_q;
    logic [PNR_W-1:0]      pnr_q;
    logic [INT_W-1:0]      int_q, int_d;
    logic                  rx_empty_q, rx_empty_d;
    logic                  start_q, clr_q, lcar_q, sqe_q;

    mmu_cmd_decode u_dec (
        .cmd_we   (cmd_we),
        .cmd_data (cmd_data),
        .op       (op)
    );

    assign link_fail  = op.enqueue & ~link_up;
    assign send       = op.enqueue & link_up & tx_ctl[TXC_EN];
    assign rx_flush   = op.flush_all | link_fail
                      | (rxc_we & rxc_data[RXC_SOFT]) | (rxc_we & ~rxc_data[RXC_ALL]);
    assign tx_flush   = op.flush_all | link_fail | (rxc_we & rxc_data[RXC_SOFT]);
    assign rx_push_en = rx_push & ~cmd_we & ~rxc_we;
    assign rx_push_ok = rx_push_en & ~rxq_full;
    assign rx_pop     = op.rm_rx | op.rm_rel_rx;
    assign tx_pop     = send | op.rm_tx;

    mmu_slot_queue #(.PTR_W(SLOT_BITS)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .flush   (rx_flush),
        .push    (rx_push_en),
        .pop     (rx_pop),
        .in_ptr  (rx_in_ptr),
        .out_ptr (rx_out_ptr),
        .empty   (rxq_empty),
        .full    (rxq_full),
        .single  (rxq_single)
    );

    mmu_slot_queue #(.PTR_W(SLOT_BITS)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .flush   (tx_flush),
        .push    (send),
        .pop     (tx_pop),
        .in_ptr  (tx_in_ptr),
        .out_ptr (tx_out_ptr),
        .empty   (txq_empty),
        .full    (txq_full),
        .single  (txq_single)
    );

    // next interrupt status and empty flag; flush is applied last so it wins
    always_comb begin
        int_d      = int_q;
        rx_empty_d = rx_empty_q;
        if (rx_push_ok) begin
            int_d[IB_RCV] = 1'b1;
            rx_empty_d    = 1'b0;
        end
        if (op.rm_rx && !rxq_empty)
            rx_empty_d = rxq_single;
        if (op.rm_rel_rx) begin
            int_d[IB_RCV] = ~rxq_empty & ~rxq_single;
            rx_empty_d    = rxq_empty | rxq_single;
        end
        if (op.alloc)
            int_d[IB_ALLOC] = 1'b1;
        if (send) begin
            int_d[IB_TX]      = 1'b1;
            int_d[IB_TXEMPTY] = 1'b1;
        end
        if (link_fail) begin
            int_d[IB_TX]  = 1'b0;
            int_d[IB_EPH] = 1'b1;
        end
        if (rx_flush) begin
            int_d[IB_RCV] = 1'b0;
            rx_empty_d    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_cnt_q <= '0;
            pnr_q       <= '0;
            int_q       <= '0;
            rx_empty_q  <= 1'b1;
            start_q     <= 1'b0;
            clr_q       <= 1'b0;
            lcar_q      <= 1'b0;
            sqe_q       <= 1'b0;
        end else begin
            int_q      <= int_d;
            rx_empty_q <= rx_empty_d;
            start_q    <= send;
            clr_q      <= link_fail & (tx_ctl[TXC_LCAR] | tx_ctl[TXC_SQE]);
            if (op.alloc) begin
                pnr_q       <= PNR_W'(alloc_cnt_q);
                alloc_cnt_q <= alloc_cnt_q + 1'b1;
            end
            if (link_fail && tx_ctl[TXC_LCAR]) lcar_q <= 1'b1;
            if (link_fail && tx_ctl[TXC_SQE])  sqe_q  <= 1'b1;
        end
    end

    assign alloc_pnr        = pnr_q;
    assign int_status       = int_q;
    assign irq              = |(int_q & int_mask);
    assign rx_empty         = rx_empty_q;
    assign tx_start         = start_q;
    assign txen_clear       = clr_q;
    assign eph_lost_carrier = lcar_q;
    assign eph_sqe          = sqe_q;

    // R4 / R5: the empty flag tracks the RX pointer pair
    a_r4_empty_flag: assert property (@(posedge clk) disable iff (rst)
        rx_empty_q == (rx_in_ptr == rx_out_ptr));
    // R8: a transmit request only follows an enqueue with link and enable up
    a_r8_start_cause: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $past(cmd_we && cmd_field(cmd_data) == CMD_ENQUEUE && link_up && tx_ctl[TXC_EN]));
    // R9: an enqueue with the link down empties both queues and flags the error
    a_r9_link_down: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_field(cmd_data) == CMD_ENQUEUE && !link_up)
        |=> (rx_in_ptr == '0 && tx_in_ptr == '0 && int_q[IB_EPH] && !int_q[IB_TX]));
    // R3: the allocated number never uses its top bit
    a_r3_pnr_top: assert property (@(posedge clk) disable iff (rst)
        !pnr_q[PNR_W-1]);
    // R12: nothing is signalled while every source is masked
    a_r12_mask_off: assert property (@(posedge clk) disable iff (rst)
        (int_mask == '0) |-> !irq);
    // R7: a flush command leaves the RX queue empty
    a_r7_flush: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && (cmd_field(cmd_data) == CMD_RESET_MMU || cmd_field(cmd_data) == CMD_RESET_FIF))
        |=> (rx_empty_q && tx_in_ptr == tx_out_ptr));

endmodule

// File: tb/mmu_cmd_engine_tb.sv
`timescale 1ns/1ps
module mmu_cmd_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_we = 1'b0, rxc_we = 1'b0, rx_push = 1'b0, link_up = 1'b1;
    logic [15:0] cmd_data = '0, rxc_data = 16'h0100, tx_ctl = 16'h0001;
    logic [7:0]  int_mask = 8'h00;
    logic [3:0]  rx_in_ptr, rx_out_ptr, tx_in_ptr, tx_out_ptr;
    logic [7:0]  alloc_pnr, int_status;
    logic        irq, rx_empty, tx_start, txen_clear, eph_lost_carrier, eph_sqe;

    int checks = 0, fails = 0;

    // reference state
    logic [3:0] m_rin, m_rout, m_tin, m_tout;
    logic [6:0] m_cnt;
    logic [7:0] m_pnr, m_int;
    logic       m_remp, m_lc, m_sqe, e_start, e_clr;

    always #2.5 clk = ~clk;

    mmu_cmd_engine u_dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data), .tx_ctl(tx_ctl),
        .link_up(link_up), .rxc_we(rxc_we), .rxc_data(rxc_data), .rx_push(rx_push),
        .int_mask(int_mask), .rx_in_ptr(rx_in_ptr), .rx_out_ptr(rx_out_ptr),
        .tx_in_ptr(tx_in_ptr), .tx_out_ptr(tx_out_ptr), .alloc_pnr(alloc_pnr),
        .int_status(int_status), .irq(irq), .rx_empty(rx_empty), .tx_start(tx_start),
        .txen_clear(txen_clear), .eph_lost_carrier(eph_lost_carrier), .eph_sqe(eph_sqe)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "rx_in", rx_in_ptr, m_rin);
        chk(req, "rx_out", rx_out_ptr, m_rout);
        chk(req, "tx_in", tx_in_ptr, m_tin);
        chk(req, "tx_out", tx_out_ptr, m_tout);
        chk(req, "pnr", alloc_pnr, m_pnr);
        chk(req, "int", int_status, m_int);
        chk(req, "irq", irq, |(m_int & int_mask));
        chk(req, "rx_empty", rx_empty, m_remp);
        chk(req, "tx_start", tx_start, e_start);
        chk(req, "txen_clear", txen_clear, e_clr);
        chk(req, "lcar", eph_lost_carrier, m_lc);
        chk(req, "sqe", eph_sqe, m_sqe);
    endtask

    task automatic model_reset();
        m_rin = 0; m_rout = 0; m_tin = 0; m_tout = 0; m_cnt = 0; m_pnr = 0;
        m_int = 0; m_remp = 1; m_lc = 0; m_sqe = 0; e_start = 0; e_clr = 0;
    endtask

    // one operation: drive at negedge, update model, sample at next negedge
    task automatic op(input logic c_we, input logic [15:0] c_d,
                      input logic r_we, input logic [15:0] r_d, input logic push);
        logic rfl, tfl;
        rfl = 0; tfl = 0; e_start = 0; e_clr = 0;
        cmd_we = c_we; cmd_data = c_d; rxc_we = r_we; rxc_data = r_d; rx_push = push;
        if (push && !c_we && !r_we && (4'(m_rin + 4'd1) != m_rout)) begin
            m_rin = m_rin + 4'd1; m_int[0] = 1; m_remp = 0;
        end
        if (r_we) begin
            if (r_d[15]) begin rfl = 1; tfl = 1; end
            if (!r_d[8]) rfl = 1;
        end
        if (c_we) begin
            case (c_d[7:4])
                4'd2: begin m_pnr = {1'b0, m_cnt}; m_cnt = m_cnt + 7'd1; m_int[3] = 1; end
                4'd4, 4'd14: begin rfl = 1; tfl = 1; end
                4'd6: if (m_rin != m_rout) begin
                          m_rout = m_rout + 4'd1; m_remp = (m_rin == m_rout);
                      end
                4'd7: if (m_tin != m_tout) m_tout = m_tout + 4'd1;
                4'd8: begin
                    m_int[0] = 0;
                    if (m_rin != m_rout) m_rout = m_rout + 4'd1;
                    if (m_rin != m_rout) begin m_int[0] = 1; m_remp = 0; end
                    else m_remp = 1;
                end
                4'd12: if (!link_up) begin
                    if (tx_ctl[10]) begin m_lc = 1; e_clr = 1; end
                    if (tx_ctl[12]) begin m_sqe = 1; e_clr = 1; end
                    m_int[1] = 0; m_int[5] = 1; rfl = 1; tfl = 1;
                end else if (tx_ctl[0]) begin
                    e_start = 1; m_tin = m_tin + 4'd1; m_tout = m_tout + 4'd1;
                    m_int[1] = 1; m_int[2] = 1;
                end
                default: ;
            endcase
        end
        if (rfl) begin m_rin = 0; m_rout = 0; m_remp = 1; m_int[0] = 0; end
        if (tfl) begin m_tin = 0; m_tout = 0; end
        @(posedge clk);
        @(negedge clk);
        cmd_we = 0; rxc_we = 0; rx_push = 0;
    endtask

    task automatic cmd(input logic [3:0] code);
        op(1'b1, {8'hA5, code, 4'h3}, 1'b0, 16'h0100, 1'b0);
    endtask

    task automatic push1();
        op(1'b0, 16'h0, 1'b0, 16'h0100, 1'b1);
    endtask

    function automatic string tag_of(input logic [3:0] code);
        case (code)
            4'd2: return "R3";
            4'd4, 4'd14: return "R7";
            4'd6, 4'd7: return "R6";
            4'd8: return "R5";
            4'd12: return link_up ? "R8" : "R9";
            default: return "R2";
        endcase
    endfunction

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");

        // R3: allocation numbers count up
        cmd(4'd2); check_all("R3");
        cmd(4'd2); check_all("R3");
        chk("R3", "pnr second", alloc_pnr, 8'h01);

        // R12: mask selects the alloc bit
        int_mask = 8'h08; #1; chk("R12", "irq on", irq, 1);
        int_mask = 8'h01; #1; chk("R12", "irq off", irq, 0);

        // R4: fill to 15, sixteenth dropped
        for (int i = 0; i < 16; i++) push1();
        check_all("R4");
        chk("R4", "rx_in full", rx_in_ptr, 4'd15);
        // R4: push ignored during a command write
        op(1'b1, 16'h0000, 1'b0, 16'h0100, 1'b1); check_all("R4");

        // R5: release with many left re-arms, last one leaves empty
        cmd(4'd8); check_all("R5");
        chk("R5", "rcv rearmed", int_status[0], 1);
        for (int i = 0; i < 14; i++) cmd(4'd8);
        check_all("R5");
        chk("R5", "rx_empty last", rx_empty, 1);

        // R10: wrap crossing
        for (int i = 0; i < 20; i++) begin push1(); cmd(4'd6); end
        check_all("R10");
        chk("R10", "rx_out wrapped", rx_out_ptr, 4'(15 + 20));

        // R8: transmit with and without enable
        tx_ctl = 16'h0001; cmd(4'd12); check_all("R8");
        tx_ctl = 16'h0000; cmd(4'd12); check_all("R8");
        tx_ctl = 16'h0001; cmd(4'd7); check_all("R6");

        // R11: accept-all cleared flushes only RX; soft reset flushes both
        cmd(4'd12); push1(); push1();
        op(1'b0, 16'h0, 1'b1, 16'h0000, 1'b0); check_all("R11");
        push1();
        op(1'b0, 16'h0, 1'b1, 16'h8100, 1'b0); check_all("R11");

        // R9: link down, each policy bit alone
        push1(); link_up = 0; tx_ctl = 16'h0401; cmd(4'd12); check_all("R9");
        tx_ctl = 16'h1001; cmd(4'd12); check_all("R9");
        link_up = 1;

        // R7: both flush codes
        push1(); cmd(4'd12); cmd(4'd4); check_all("R7");
        push1(); cmd(4'd14); check_all("R7");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [3:0] code;
            k = $urandom_range(0, 99);
            int_mask = 8'($urandom());
            if ($urandom_range(0, 9) == 0) link_up = ($urandom_range(0, 4) != 0);
            if ($urandom_range(0, 9) == 0) tx_ctl = 16'($urandom()) & 16'h1401;
            if (k < 45) begin
                op(1'b0, 16'h0, 1'b0, 16'h0100, 1'b1); check_all("R4");
            end else if (k < 90) begin
                code = 4'($urandom());
                op(1'b1, {8'($urandom()), code, 4'($urandom())}, 1'b0, 16'h0100,
                   1'($urandom()));
                check_all(tag_of(code));
            end else begin
                op(1'b0, 16'h0, 1'b1,
                   {($urandom_range(0, 3) == 0), 6'd0, ($urandom_range(0, 3) != 0), 8'($urandom())},
                   1'($urandom()));
                check_all("R11");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule